// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers thirteen level-sensitive interrupt lines from peripherals into a 32-bit pending-status register. A 32-bit enable register qualifies them. A transition on a source line updates that source's own status bit: a rising edge sets it and a falling edge clears it. Each source belongs to one of three CPU priority groups: 3, 5 or 6. The block presents the highest group that has an enabled pending bit as a 3-bit CPU priority level, together with the autovector number for that group.

Software reaches both registers through a plain 32-bit register port. A write replaces the whole register and takes effect on the next clock edge. A read returns the register combinationally from the address. The port has no handshake: every write strobe is accepted in the cycle it is presented, and a read is valid while the address is held. A separate strobe carries the DMA-enable bit of the SCSI control byte, and that strobe drives status bit 26 directly.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset the status register, the enable register, the priority level and the vector all read zero.
- R2: A rising edge on a source line sets that source's status bit. Line index to bit: 0 floppy→7, 1 keyboard/mouse→3, 2 power→2, 3 Ethernet receive→9, 4 Ethernet transmit→10, 5 SCSI→12, 6 clock→5, 7 serial→17, 8 Ethernet transmit DMA→28, 9 Ethernet receive DMA→27, 10 SCSI DMA→26, 11 sound→23, 12 serial DMA→21.
- R3: A falling edge on a source line clears that source's status bit.
- R4: A write to offset 0x7000 replaces the whole status register, and a read of 0x7000 returns it.
- R5: A write to offset 0x7800 replaces the whole enable register, and a read of 0x7800 returns it. A write to any other offset changes neither register, and a read of any other offset returns zero.
- R6: A strobe on the SCSI control path copies its DMA-enable bit into status bit 26, setting the bit when the DMA-enable bit is 1 and clearing it when it is 0.
- R7: The priority level is the highest group (6, then 5, then 3) with at least one bit set in status AND enable. Lines 0–6 form group 3, line 7 forms group 5 and lines 8–12 form group 6. The level is 0 when no grouped bit is pending, so bits outside the groups have no effect on it.
- R8: The vector is 27 for level 3, 29 for level 5, 30 for level 6 and 0 for level 0.
- R9: The level and the vector are registered: they follow the status and enable registers one clock later.
- R10: When a source edge and a register write or a SCSI control strobe reach the same bit in the same cycle, the source edge decides that bit. The other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | 13 | Level interrupt lines, indexed as in R2 |
| scsi_ctl_we | input | 1 | SCSI control byte write strobe |
| scsi_ctl_dma | input | 1 | DMA-enable bit of the written SCSI control byte |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_ipl | output | 3 | Registered CPU priority level |
| cpu_vec | output | 8 | Registered autovector number |

## Verification
The bench builds the block with its default parameters: 32-bit registers, 16-bit offsets at 0x7000 and 0x7800, and vectors 27, 29 and 30. This build covers all thirteen line-to-bit positions. It also exposes the one shared bit, 26, where a source line and the SCSI control strobe compete, and the one-cycle lag between a status change and the level output. A behavioural model in the bench tracks both registers, the level and the vector on every clock. Directed sequences exercise group ordering under the enable register, ungrouped bits, unmapped offsets and same-cycle conflicts.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

  localparam int NUM_SRC = 13;
  localparam int SCSI_DMA_BIT = 26;

  // status bit position owned by each source line
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 7;
      1:       return 3;
      2:       return 2;
      3:       return 9;
      4:       return 10;
      5:       return 12;
      6:       return 5;
      7:       return 17;
      8:       return 28;
      9:       return 27;
      10:      return 26;
      11:      return 23;
      default: return 21;
    endcase
  endfunction

  // priority group of each source line
  function automatic int src_level(input int idx);
    if (idx <= 6)      return 3;
    else if (idx == 7) return 5;
    else               return 6;
  endfunction

  function automatic logic [31:0] group_bits(input int lvl);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_level(i) == lvl) m[src_bit(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = lines[g] & ~prev_q[g];
    assign fall[g] = ~lines[g] & prev_q[g];
  end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_grp_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 16,
  parameter int                N          = 13,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFF   = 'h7800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      rise,
  input  logic [N-1:0]      fall,
  input  logic              scsi_ctl_we,
  input  logic              scsi_ctl_dma,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] hw_set, hw_clr, sw_val, status_d;

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    for (int i = 0; i < N; i++) begin
      if (rise[i]) hw_set[src_bit(i)] = 1'b1;
      if (fall[i]) hw_clr[src_bit(i)] = 1'b1;
    end
  end

  // software value first, then SCSI control, then source edges override
  always_comb begin
    sw_val = (bus_wr && bus_addr == STATUS_OFF) ? bus_wdata : status_q;
    if (scsi_ctl_we) sw_val[SCSI_DMA_BIT] = scsi_ctl_dma;
    status_d = (sw_val & ~hw_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      if (bus_wr && bus_addr == MASK_OFF) mask_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/irq_level_encode.sv
module irq_level_encode
  import irq_grp_pkg::*;
#(
  parameter int               DATA_W = 32,
  parameter int               VEC_W  = 8,
  parameter logic [VEC_W-1:0] VEC_L3 = 8'd27,
  parameter logic [VEC_W-1:0] VEC_L5 = 8'd29,
  parameter logic [VEC_W-1:0] VEC_L6 = 8'd30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  output logic [2:0]        ipl,
  output logic [VEC_W-1:0]  vec
);
  localparam logic [DATA_W-1:0] G3 = DATA_W'(group_bits(3));
  localparam logic [DATA_W-1:0] G5 = DATA_W'(group_bits(5));
  localparam logic [DATA_W-1:0] G6 = DATA_W'(group_bits(6));

  logic [DATA_W-1:0] pend;
  logic [2:0]        ipl_d;
  logic [VEC_W-1:0]  vec_d;

  always_comb begin
    pend = status & mask;
    if (|(pend & G6)) begin
      ipl_d = 3'd6; vec_d = VEC_L6;
    end else if (|(pend & G5)) begin
      ipl_d = 3'd5; vec_d = VEC_L5;
    end else if (|(pend & G3)) begin
      ipl_d = 3'd3; vec_d = VEC_L3;
    end else begin
      ipl_d = 3'd0; vec_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl <= '0;
      vec <= '0;
    end else begin
      ipl <= ipl_d;
      vec <= vec_d;
    end
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 16,
  parameter int                VEC_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFF   = 'h7800,
  parameter logic [VEC_W-1:0]  VEC_L3     = 8'd27,
  parameter logic [VEC_W-1:0]  VEC_L5     = 8'd29,
  parameter logic [VEC_W-1:0]  VEC_L6     = 8'd30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_lines,
  input  logic                scsi_ctl_we,
  input  logic                scsi_ctl_dma,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2:0]          cpu_ipl,
  output logic [VEC_W-1:0]    cpu_vec
);
  logic [NUM_SRC-1:0] rise, fall;
  logic [DATA_W-1:0]  status_q, mask_q;

  irq_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lines(src_lines), .rise(rise), .fall(fall)
  );

  irq_status_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(NUM_SRC),
    .STATUS_OFF(STATUS_OFF), .MASK_OFF(MASK_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .scsi_ctl_we(scsi_ctl_we), .scsi_ctl_dma(scsi_ctl_dma),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status_q(status_q), .mask_q(mask_q)
  );

  irq_level_encode #(
    .DATA_W(DATA_W), .VEC_W(VEC_W),
    .VEC_L3(VEC_L3), .VEC_L5(VEC_L5), .VEC_L6(VEC_L6)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .status(status_q), .mask(mask_q),
    .ipl(cpu_ipl), .vec(cpu_vec)
  );

  always_comb begin
    if (bus_addr == STATUS_OFF)    bus_rdata = status_q;
    else if (bus_addr == MASK_OFF) bus_rdata = mask_q;
    else                           bus_rdata = '0;
  end
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk
  import irq_grp_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 16,
  parameter int                VEC_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFF   = 'h7800,
  parameter logic [VEC_W-1:0]  VEC_L3     = 8'd27,
  parameter logic [VEC_W-1:0]  VEC_L5     = 8'd29,
  parameter logic [VEC_W-1:0]  VEC_L6     = 8'd30
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_lines,
  input logic               scsi_ctl_we,
  input logic               scsi_ctl_dma,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [2:0]         cpu_ipl,
  input logic [VEC_W-1:0]   cpu_vec,
  input logic [DATA_W-1:0]  status,
  input logic [DATA_W-1:0]  mask
);
  localparam logic [DATA_W-1:0] GALL =
    DATA_W'(group_bits(3) | group_bits(5) | group_bits(6));
  localparam logic [DATA_W-1:0] G6 = DATA_W'(group_bits(6));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int B = src_bit(g);
    assert_src_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_lines[g]) |=> status[B]);
    assert_src_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(src_lines[g]) |=> !status[B]);
  end

  assert_status_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && bus_wr && bus_addr == STATUS_OFF && !scsi_ctl_we && $stable(src_lines)
    |=> status == $past(bus_wdata));

  assert_mask_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == MASK_OFF |=> mask == $past(bus_wdata));

  assert_scsi_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && scsi_ctl_we && $stable(src_lines[10])
    |=> status[SCSI_DMA_BIT] == $past(scsi_ctl_dma));

  assert_legal_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ipl == 3'd0 || cpu_ipl == 3'd3 || cpu_ipl == 3'd5 || cpu_ipl == 3'd6);

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status & mask & GALL) == '0 |=> cpu_ipl == 3'd0);

  assert_vec_l3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ipl == 3'd3 |-> cpu_vec == VEC_L3);
  assert_vec_l5_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ipl == 3'd5 |-> cpu_vec == VEC_L5);
  assert_vec_l6_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ipl == 3'd6 |-> cpu_vec == VEC_L6);
  assert_vec_l0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ipl == 3'd0 |-> cpu_vec == '0);

  assert_lvl6_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & mask & G6) != '0 |=> cpu_ipl == 3'd6);
endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .STATUS_OFF(STATUS_OFF), .MASK_OFF(MASK_OFF),
  .VEC_L3(VEC_L3), .VEC_L5(VEC_L5), .VEC_L6(VEC_L6)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lines(src_lines),
  .scsi_ctl_we(scsi_ctl_we), .scsi_ctl_dma(scsi_ctl_dma),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cpu_ipl(cpu_ipl), .cpu_vec(cpu_vec),
  .status(status_q), .mask(mask_q)
);

// File: tb/irq_group_ctrl_test.sv
`timescale 1ns/1ps
module irq_group_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NS = 13;
  localparam logic [15:0] A_ST = 16'h7000;
  localparam logic [15:0] A_MK = 16'h7800;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [NS-1:0] src_lines = '0;
  logic        scsi_ctl_we = 0, scsi_ctl_dma = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0]  cpu_ipl;
  logic [7:0]  cpu_vec;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  int bmap [NS] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
  int blvl [NS] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

  irq_group_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_lines(src_lines),
    .scsi_ctl_we(scsi_ctl_we), .scsi_ctl_dma(scsi_ctl_dma),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_ipl(cpu_ipl), .cpu_vec(cpu_vec)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model
  logic [31:0] m_st, m_mk;
  logic [NS-1:0] m_prev;
  int m_ipl, m_vec;

  function automatic int vec_of(input int l);
    return (l == 6) ? 30 : (l == 5) ? 29 : (l == 3) ? 27 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_mk = '0; m_prev = '0; m_ipl = 0; m_vec = 0;
    end else begin
      int lv;
      logic [31:0] nst;
      lv = 0;
      for (int i = 0; i < NS; i++)
        if (m_st[bmap[i]] && m_mk[bmap[i]] && blvl[i] > lv) lv = blvl[i];
      nst = m_st;
      if (bus_wr && bus_addr == A_ST) nst = bus_wdata;
      if (scsi_ctl_we) nst[26] = scsi_ctl_dma;
      for (int i = 0; i < NS; i++) begin
        if (src_lines[i] && !m_prev[i]) nst[bmap[i]] = 1'b1;
        if (!src_lines[i] && m_prev[i]) nst[bmap[i]] = 1'b0;
      end
      if (bus_wr && bus_addr == A_MK) m_mk = bus_wdata;
      m_st = nst;
      m_prev = src_lines;
      m_ipl = lv;
      m_vec = vec_of(lv);
    end
  end

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] er;
      er = (bus_addr == A_ST) ? m_st : (bus_addr == A_MK) ? m_mk : 32'h0;
      chk("R7", "model level", cpu_ipl, m_ipl);
      chk("R8", "model vector", cpu_vec, m_vec);
      chk("R4", "model readback", bus_rdata, er);
    end
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic summary;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    rd(A_ST, v); chk("R1", "status after reset", v, 0);
    rd(A_MK, v); chk("R1", "mask after reset", v, 0);
    chk("R1", "level after reset", cpu_ipl, 0);
    chk("R1", "vector after reset", cpu_vec, 0);

    wr(A_MK, 32'hFFFF_FFFF);
    rd(A_MK, v); chk("R5", "mask readback", v, 32'hFFFF_FFFF);

    // every line: set, lag, level, clear
    for (int i = 0; i < NS; i++) begin
      src_lines[i] = 1'b1;
      tick();
      rd(A_ST, v); chk("R2", $sformatf("rise line %0d", i), v, 32'h1 << bmap[i]);
      chk("R9", "level lags status", cpu_ipl, 0);
      tick();
      chk("R7", $sformatf("level line %0d", i), cpu_ipl, blvl[i]);
      chk("R8", $sformatf("vector line %0d", i), cpu_vec, vec_of(blvl[i]));
      src_lines[i] = 1'b0;
      tick();
      rd(A_ST, v); chk("R3", $sformatf("fall line %0d", i), v, 0);
      tick();
      chk("R9", "level drops", cpu_ipl, 0);
    end

    // group ordering under the enable register
    src_lines[1] = 1; src_lines[7] = 1; src_lines[11] = 1;
    tick(); tick();
    chk("R7", "three groups pending", cpu_ipl, 6);
    chk("R8", "vector group 6", cpu_vec, 30);
    wr(A_MK, ~(32'h1 << 23)); tick();
    chk("R7", "group 6 masked", cpu_ipl, 5);
    chk("R8", "vector group 5", cpu_vec, 29);
    wr(A_MK, ~((32'h1 << 23) | (32'h1 << 17))); tick();
    chk("R7", "groups 6 and 5 masked", cpu_ipl, 3);
    wr(A_MK, 32'h0); tick();
    chk("R7", "all masked", cpu_ipl, 0);
    src_lines = '0;
    wr(A_MK, 32'hFFFF_FFFF);
    tick(); tick();

    // software status writes, ungrouped bits
    wr(A_ST, 32'h0000_0001); tick();
    rd(A_ST, v); chk("R4", "status write", v, 1);
    chk("R7", "ungrouped bit gives level 0", cpu_ipl, 0);
    wr(A_ST, 32'hA5A5_0000); tick();
    rd(A_ST, v); chk("R4", "status pattern", v, 32'hA5A5_0000);
    wr(A_ST, 0);

    // unmapped offset
    wr(16'h1234, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R5", "status after stray write", v, 0);
    rd(A_MK, v); chk("R5", "mask after stray write", v, 32'hFFFF_FFFF);
    tick();
    rd(16'h1234, v); chk("R5", "stray read", v, 0);

    // SCSI control path
    scsi_ctl_we = 1; scsi_ctl_dma = 1; tick(); scsi_ctl_we = 0;
    rd(A_ST, v); chk("R6", "dma bit sets 26", v, 32'h1 << 26);
    tick();
    chk("R7", "level from bit 26", cpu_ipl, 6);
    scsi_ctl_we = 1; scsi_ctl_dma = 0; tick(); scsi_ctl_we = 0;
    rd(A_ST, v); chk("R6", "dma bit clears 26", v, 0);

    // same-cycle conflicts
    src_lines[6] = 1; wr(A_ST, 32'h0);
    rd(A_ST, v); chk("R10", "rise beats write", v, 32'h1 << 5);
    src_lines[6] = 0; wr(A_ST, 32'h0000_0120);
    rd(A_ST, v); chk("R10", "fall beats write", v, 32'h0000_0100);
    src_lines[10] = 1; scsi_ctl_we = 1; scsi_ctl_dma = 0;
    tick(); scsi_ctl_we = 0;
    rd(A_ST, v); chk("R10", "rise beats scsi ctl", v, 32'h0000_0100 | (32'h1 << 26));
    src_lines = '0; wr(A_ST, 0);
    tick(); tick();
    summary();
  end
endmodule